// File: doc/BRIEF.md
# Runahead Store Cache

While a core runs ahead of an unresolved long-latency miss, its stores must not reach real memory, yet the loads that follow still want the values those stores would have left behind. This block is a tiny direct-mapped buffer for that purpose. Each store that leaves the window during runahead writes its word together with a poison flag. The flag says the value was computed from data that had not yet arrived. Later loads look the buffer up by word address and get back a hit indication, the word, and the poison flag. On a miss the load falls back to the normal memory path.

Correctness is best-effort by design. A store that maps to an occupied slot with a different tag replaces it silently, and nothing is ever written back. When runahead ends, the core pulses the clear input and every slot is emptied in a single cycle. A lookup presented in cycle t is answered by registered outputs in cycle t+1. The answer reflects the contents as they stood before any write or clear accepted in cycle t.

Top module: `ra_store_cache`

## Requirements
- R1: After reset every lookup misses: the response has hit=0, data=0 and poison=0.
- R2: A lookup of an address written in an earlier cycle returns hit=1 with the stored word in the cycle after the lookup request.
- R3: A lookup that hits a slot written with poison=1 returns poison=1, and poison is never 1 without hit.
- R4: A store to the same slot index (address bits [IDX_W-1:0]) with a different tag replaces the older entry. The older address then misses and the newer one hits.
- R5: A lookup whose index matches a valid slot but whose upper address bits differ misses.
- R6: A clear pulse empties every slot: any lookup issued in the cycle after the pulse misses.
- R7: A lookup and a store to the same index in the same cycle return the contents held before that store.
- R8: When clear and a store coincide, clear wins and the store is dropped.
- R9: rsp_valid is 1 exactly one cycle after a cycle with rd_en=1. When rsp_valid is 0, hit, data and poison are all 0.
- R10: A lookup issued in the same cycle as a clear pulse returns the contents held before the clear.
- R11: Rewriting an address replaces both its word and its poison flag, including changing poison from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store from a retiring runahead instruction |
| wr_addr | input | ADDR_W | Word address of the store |
| wr_data | input | DATA_W | Store word |
| wr_inv | input | 1 | Poison flag of the store |
| rd_en | input | 1 | Lookup request |
| rd_addr | input | ADDR_W | Word address of the lookup |
| flush | input | 1 | Clear every slot (runahead exit) |
| rsp_valid | output | 1 | Response present (one cycle after rd_en) |
| rsp_hit | output | 1 | Lookup found a matching slot |
| rsp_data | output | DATA_W | Word from the matching slot, else 0 |
| rsp_inv | output | 1 | Poison flag from the matching slot, else 0 |

## Verification
The hardest cases to reach are the coincident ones: a lookup and a store landing on the same index in one cycle, and a clear arriving together with a store or a lookup. Directed sequences first fill every slot, then issue these collisions on slots known to hold older data, so that old-versus-new contents give different answers. A long random phase then draws addresses from a few tags over all indices, with frequent stores, lookups and occasional clears. A behavioural model checks every cycle's response.

// File: rtl/ra_sc_pkg.sv
package ra_sc_pkg;

    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_ENTRIES = 16;

    // Update applied to the slot array at the coming edge.
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_WRITE = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_op_e;

    // Clear outranks a store in the same cycle.
    function automatic upd_op_e pick_op(input logic clr, input logic we);
        if (clr)
            return UPD_CLEAR;
        else if (we)
            return UPD_WRITE;
        else
            return UPD_NONE;
    endfunction

endpackage

// File: rtl/ra_sc_index.sv
module ra_sc_index #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    always_comb begin
        idx = addr[IDX_W-1:0];
        tag = addr[ADDR_W-1:IDX_W];
    end

endmodule

// File: rtl/ra_sc_array.sv
module ra_sc_array
    import ra_sc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 28,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  upd_op_e             op,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_inv,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_vld,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_inv,
    output logic [ENTRIES-1:0]  slot_vld
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             inv;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
    } slots_t;

    slots_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            UPD_CLEAR: begin
                st_d.vld = '0;
            end
            UPD_WRITE: begin
                st_d.vld[wr_idx]  = 1'b1;
                st_d.inv[wr_idx]  = wr_inv;
                st_d.tag[wr_idx]  = wr_tag;
                st_d.data[wr_idx] = wr_data;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Read port sees registered contents: older than any same-cycle update.
    always_comb begin
        rd_vld   = st_q.vld[rd_idx];
        rd_tag   = st_q.tag[rd_idx];
        rd_data  = st_q.data[rd_idx];
        rd_inv   = st_q.inv[rd_idx];
        slot_vld = st_q.vld;
    end

endmodule

// File: rtl/ra_sc_lookup.sv
module ra_sc_lookup #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              ent_vld,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [DATA_W-1:0] ent_data,
    input  logic              ent_inv,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_inv
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              inv;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic match;

    always_comb begin
        match = ent_vld && (ent_tag == req_tag);
        rsp_d = '0;
        if (req) begin
            rsp_d.valid = 1'b1;
            if (match) begin
                rsp_d.hit  = 1'b1;
                rsp_d.inv  = ent_inv;
                rsp_d.data = ent_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    always_comb begin
        rsp_valid = rsp_q.valid;
        rsp_hit   = rsp_q.hit;
        rsp_data  = rsp_q.data;
        rsp_inv   = rsp_q.inv;
    end

endmodule

// File: rtl/ra_store_cache.sv
module ra_store_cache
    import ra_sc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ENTRIES = DEF_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_inv,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_inv
);

    logic [IDX_W-1:0]   w_idx, r_idx;
    logic [TAG_W-1:0]   w_tag, r_tag;
    logic               e_vld, e_inv;
    logic [TAG_W-1:0]   e_tag;
    logic [DATA_W-1:0]  e_data;
    logic [ENTRIES-1:0] slot_vld;
    upd_op_e            op;

    always_comb op = pick_op(flush, wr_en);

    ra_sc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_widx (
        .addr (wr_addr),
        .idx  (w_idx),
        .tag  (w_tag)
    );

    ra_sc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ridx (
        .addr (rd_addr),
        .idx  (r_idx),
        .tag  (r_tag)
    );

    ra_sc_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wr_idx   (w_idx),
        .wr_tag   (w_tag),
        .wr_data  (wr_data),
        .wr_inv   (wr_inv),
        .rd_idx   (r_idx),
        .rd_vld   (e_vld),
        .rd_tag   (e_tag),
        .rd_data  (e_data),
        .rd_inv   (e_inv),
        .slot_vld (slot_vld)
    );

    ra_sc_lookup #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rd_en),
        .req_tag   (r_tag),
        .ent_vld   (e_vld),
        .ent_tag   (e_tag),
        .ent_data  (e_data),
        .ent_inv   (e_inv),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_data  (rsp_data),
        .rsp_inv   (rsp_inv)
    );

endmodule

// File: rtl/ra_sc_checker.sv
module ra_sc_checker #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               rd_en,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               rsp_inv,
    input logic [ENTRIES-1:0] slot_vld
);

    // R9: a response follows every request, and only requests
    a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);
    a_r9_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);
    a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_inv && rsp_data == '0));

    // R3: poison only accompanies a hit
    a_r3_inv_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_inv |-> rsp_hit);

    // R6: clear empties all slots
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_vld == '0));

    // R8: a store coinciding with clear leaves nothing behind
    a_r8_clear_beats_store: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && wr_en) |=> (slot_vld == '0));

    // R2: an accepted store occupies its slot
    a_r2_store_fills_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> slot_vld[$past(wr_addr[IDX_W-1:0])]);

endmodule

bind ra_store_cache ra_sc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_en     (rd_en),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_data  (rsp_data),
    .rsp_inv   (rsp_inv),
    .slot_vld  (slot_vld)
);

// File: tb/sim_ra_store_cache.sv
`timescale 1ns/1ps
module sim_ra_store_cache;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_inv = 1'b0, rd_en = 1'b0, flush = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rsp_valid, rsp_hit, rsp_inv;
    logic [DW-1:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference: last store per slot, keyed by address modulo NE
    bit            m_used [NE];
    logic [AW-1:0] m_addr [NE];
    logic [DW-1:0] m_data [NE];
    bit            m_inv  [NE];

    always #2 clk = ~clk;

    ra_store_cache #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_inv(wr_inv), .rd_en(rd_en), .rd_addr(rd_addr),
        .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .rsp_inv(rsp_inv)
    );

    task automatic check(input string tag, input logic [DW+2:0] act, input logic [DW+2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid/hit/inv/data=%h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, predict, clock, compare at next negedge
    task automatic cyc(input string tag, input bit we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input bit wi, input bit re,
                       input logic [AW-1:0] ra, input bit fl);
        int ri, wix;
        logic [DW+2:0] exp;
        wr_en = we; wr_addr = wa; wr_data = wd; wr_inv = wi;
        rd_en = re; rd_addr = ra; flush = fl;
        ri  = int'(ra % NE);
        wix = int'(wa % NE);
        exp = '0;
        if (re) begin
            exp[DW+2] = 1'b1;
            if (m_used[ri] && m_addr[ri] == ra)
                exp = {1'b1, 1'b1, m_inv[ri], m_data[ri]};
        end
        if (fl) begin
            for (int k = 0; k < NE; k++) m_used[k] = 1'b0;
        end else if (we) begin
            m_used[wix] = 1'b1; m_addr[wix] = wa; m_data[wix] = wd; m_inv[wix] = wi;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {rsp_valid, rsp_hit, rsp_inv, rsp_data}, exp);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        cyc(tag, 0, '0, '0, 0, 1, a, 0);
    endtask

    task automatic wr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit i);
        cyc(tag, 1, a, d, i, 0, '0, 0);
    endtask

    initial begin
        for (int k = 0; k < NE; k++) m_used[k] = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset", {rsp_valid, rsp_hit, rsp_inv, rsp_data}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        for (int k = 0; k < 8; k++) rd("R1", 32'h1000 + 32'(k * 7));
        cyc("R9 idle", 0, '0, '0, 0, 0, '0, 0);

        // R2: fill every slot then read back
        for (int k = 0; k < NE; k++) wr("R2 fill", 32'h100 + 32'(k), 32'hA000_0000 + 32'(k), 0);
        for (int k = 0; k < NE; k++) rd("R2", 32'h100 + 32'(k));

        // R3 / R4: poisoned store evicts slot 5
        wr("R3 store", 32'h205, 32'hDEAD_0005, 1);
        rd("R3", 32'h205);
        rd("R4 old", 32'h105);
        rd("R4 new", 32'h205);

        // R5: same index, other tag
        rd("R5", 32'h305);
        rd("R5", 32'h1109);

        // R7: read and write same index together
        cyc("R7", 1, 32'h405, 32'hBEEF_0405, 1, 1, 32'h205, 0);
        rd("R7 after", 32'h405);
        cyc("R7 same addr", 1, 32'h405, 32'h1234_5678, 1, 1, 32'h405, 0);

        // R11: rewrite clears poison
        wr("R11 store", 32'h405, 32'h0000_C0DE, 0);
        rd("R11", 32'h405);

        // R10 then R6
        cyc("R10", 0, '0, '0, 0, 1, 32'h10A, 1);
        for (int k = 0; k < NE; k++) rd("R6", 32'h100 + 32'(k));

        // R8: clear wins over a store
        wr("R8 prep", 32'h103, 32'h3, 0);
        cyc("R8", 1, 32'h10C, 32'hC, 0, 0, '0, 1);
        rd("R8 dropped", 32'h10C);
        rd("R8 cleared", 32'h103);

        // mixed random traffic over few tags
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] a1, a2;
            int r;
            r  = int'($urandom_range(0, 99));
            a1 = 32'h40 + 32'($urandom_range(0, 3) * NE) + 32'($urandom_range(0, NE - 1));
            a2 = 32'h40 + 32'($urandom_range(0, 3) * NE) + 32'($urandom_range(0, NE - 1));
            cyc("R2 mix", r < 55, a1, $urandom, bit'($urandom_range(0, 1)),
                r > 30, a2, r == 99);
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule